// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller (Three-State)

This block holds the coherence state of every line in a small direct-mapped, write-back cache that shares a broadcast bus with other cores. Each line is Invalid, Shared (clean, and other caches may hold copies) or Modified (dirty, and no other cache holds it). The processor side presents one read or write request per cycle. The controller answers with the bus message that the request needs: a read miss, a write miss, or an upgrade that invalidates the other copies. It also reports whether the request was served locally, and it raises an eviction strobe when a dirty victim has to leave the cache.

The snoop side takes the messages that other cores place on the bus. It looks them up through a separate tag comparison, so a snoop never holds up the processor side. A snooped message that hits a Shared line invalidates the line when it is a write miss or an upgrade. A snooped message that hits a Modified line raises a flush strobe, meaning the dirty block is written back and supplied to the requester. The line then drops to Shared after a read miss and to Invalid after any other message. Bus arbitration and the data array sit outside the block. Each bus message is assumed to complete in the cycle in which it is issued.

Each line runs its own state machine with the states LN_INV, LN_SHR and LN_MOD. The named transitions are:
- LN_INV to LN_SHR on a read miss.
- LN_INV to LN_MOD on a write miss.
- LN_SHR to LN_MOD on a write upgrade.
- LN_SHR to LN_INV on a snooped write miss or upgrade.
- LN_MOD to LN_SHR on a snooped read miss (with a flush).
- LN_MOD to LN_INV on a snooped write miss or upgrade (with a flush).
- Any state to LN_SHR or LN_MOD on a replacement with a new tag.

When a snoop and a processor request reach the same line in the same cycle, the snoop is applied first.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. While no request or snoop is presented, all outputs are zero. The state encoding is Invalid=0, Shared=1, Modified=2.
- R2: A processor read that misses (the line is Invalid or holds another tag) produces, one cycle later, bus_op=1 (read miss) with bus_addr equal to the request address. The line then holds the new tag in Shared, cpu_state=1 and cpu_hit=0. Address bits [IDX_W-1:0] are the line index and the remaining upper bits are the tag.
- R3: A processor write that misses produces bus_op=2 (write miss) and leaves the line Modified. A write that hits a Shared line produces bus_op=3 (upgrade) and leaves the line Modified. In both cases cpu_state=2 and cpu_hit=0.
- R4: A read hit on a Shared or Modified line, or a write hit on a Modified line, gives cpu_hit=1 and bus_op=0 one cycle later, and the line state does not change.
- R5: A snooped write miss (snp_op=2) or upgrade (snp_op=3) that hits a Shared line moves the line to Invalid. A snooped read miss (snp_op=1) on a Shared line leaves it Shared. Neither case raises flush.
- R6: A snooped read miss that hits a Modified line raises flush one cycle later, with flush_addr equal to the snooped address, and the line becomes Shared (snp_state=1).
- R7: A snooped write miss or upgrade that hits a Modified line raises flush with the snooped address, and the line becomes Invalid (snp_state=0).
- R8: A snoop whose block is not held (the line is Invalid or its tag differs) changes nothing. The bench checks this by a later processor access to the held line.
- R9: A processor miss whose line holds a Modified block of another tag raises evict, with evict_addr equal to the victim's tag and index, in the same cycle as the miss message.
- R10: When a snoop and a processor request address the same line in one cycle, the snoop takes effect first, and the processor request is judged against the state that the snoop leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid for this cycle |
| cpu_we | input | 1 | Request is a write (1) or a read (0) |
| cpu_addr | input | ADDR_W | Block address of the processor request |
| snp_op | input | 2 | Snooped bus message: 0 none, 1 read miss, 2 write miss, 3 upgrade |
| snp_addr | input | ADDR_W | Block address of the snooped message |
| bus_op | output | 2 | Message this cache places on the bus (same encoding as snp_op) |
| bus_addr | output | ADDR_W | Address of that message, zero when bus_op is 0 |
| cpu_hit | output | 1 | Request served without any bus message |
| cpu_state | output | 2 | State of the requested block after the request |
| snp_state | output | 2 | State of the snooped block after the snoop, 0 if not held |
| flush | output | 1 | Write back and supply a dirty block for a snoop |
| flush_addr | output | ADDR_W | Address of the flushed block |
| evict | output | 1 | Write back a dirty victim on replacement |
| evict_addr | output | ADDR_W | Address of the evicted block |

## Verification
The hardest situation to reach is a snoop and a processor request that land on the same line in the same cycle, especially while the line is Modified. The outcome then depends on the snoop acting first: a write can turn into a write miss with no eviction, and a read that would have hit can arrive together with a flush. A directed sequence first brings the line into each state and then issues the colliding pairs. A long pseudo-random run follows, using two tags per index and a bias that makes the snoop copy the processor address. It drives every line through every transition, including replacement of dirty victims, and an arithmetic model in the bench predicts each cycle's outputs.

// File: rtl/msi_ctrl_pkg.sv
package msi_ctrl_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE    = 2'd0,
        BUS_RDMISS  = 2'd1,
        BUS_WRMISS  = 2'd2,
        BUS_UPGRADE = 2'd3
    } bus_msg_e;

endpackage

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
    import msi_ctrl_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_sel,
    input  bus_msg_e          snp_msg,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    output line_state_e       snp_result,
    output logic              snp_flush,
    output line_state_e       cpu_result,
    output bus_msg_e          cpu_msg,
    output logic              cpu_hit,
    output logic              cpu_evict,
    output logic [TAG_W-1:0]  victim_tag
);

    line_state_e      state_q, mid_state, next_state;
    logic [TAG_W-1:0] tag_q, next_tag;
    logic             snp_match, cpu_match;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_INV;
            tag_q   <= '0;
        end else begin
            state_q <= next_state;
            tag_q   <= next_tag;
        end
    end

    // snoop stage: acts on the stored state before the processor stage
    assign snp_match = snp_sel && (snp_msg != BUS_NONE) &&
                       (state_q != LN_INV) && (tag_q == snp_tag);

    always_comb begin
        mid_state = state_q;
        snp_flush = 1'b0;
        if (snp_match) begin
            unique case (state_q)
                LN_SHR: mid_state = (snp_msg == BUS_RDMISS) ? LN_SHR : LN_INV;
                LN_MOD: begin
                    snp_flush = 1'b1;
                    mid_state = (snp_msg == BUS_RDMISS) ? LN_SHR : LN_INV;
                end
                default: mid_state = state_q;
            endcase
        end
        snp_result = snp_match ? mid_state : LN_INV;
    end

    // processor stage: judged against the post-snoop state
    assign cpu_match = (mid_state != LN_INV) && (tag_q == cpu_tag);

    always_comb begin
        next_state = mid_state;
        next_tag   = tag_q;
        cpu_msg    = BUS_NONE;
        cpu_hit    = 1'b0;
        cpu_evict  = 1'b0;
        if (cpu_sel) begin
            if (cpu_match) begin
                unique case (mid_state)
                    LN_SHR: begin
                        if (cpu_we) begin
                            cpu_msg    = BUS_UPGRADE;
                            next_state = LN_MOD;
                        end else begin
                            cpu_hit = 1'b1;
                        end
                    end
                    LN_MOD:  cpu_hit = 1'b1;
                    default: cpu_hit = 1'b0;
                endcase
            end else begin
                cpu_evict  = (mid_state == LN_MOD);
                cpu_msg    = cpu_we ? BUS_WRMISS : BUS_RDMISS;
                next_state = cpu_we ? LN_MOD : LN_SHR;
                next_tag   = cpu_tag;
            end
        end
        cpu_result = next_state;
    end

    assign victim_tag = tag_q;

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cpu_hit,
    output logic [1:0]        cpu_state,
    output logic [1:0]        snp_state,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_addr,
    output logic              evict,
    output logic [ADDR_W-1:0] evict_addr
);

    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    bus_msg_e         snp_msg;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign snp_msg = bus_msg_e'(snp_op);

    line_state_e      ln_snp_res [LINES];
    logic             ln_flush   [LINES];
    line_state_e      ln_cpu_res [LINES];
    bus_msg_e         ln_msg     [LINES];
    logic             ln_hit     [LINES];
    logic             ln_evict   [LINES];
    logic [TAG_W-1:0] ln_victim  [LINES];

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        msi_line_fsm #(.TAG_W(TAG_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .snp_sel    (snp_idx == IDX_W'(gi)),
            .snp_msg    (snp_msg),
            .snp_tag    (snp_tag),
            .cpu_sel    (cpu_req && (cpu_idx == IDX_W'(gi))),
            .cpu_we     (cpu_we),
            .cpu_tag    (cpu_tag),
            .snp_result (ln_snp_res[gi]),
            .snp_flush  (ln_flush[gi]),
            .cpu_result (ln_cpu_res[gi]),
            .cpu_msg    (ln_msg[gi]),
            .cpu_hit    (ln_hit[gi]),
            .cpu_evict  (ln_evict[gi]),
            .victim_tag (ln_victim[gi])
        );
    end

    bus_msg_e    sel_msg;
    line_state_e sel_cpu_res, sel_snp_res;
    logic        sel_hit, sel_evict, sel_flush;

    assign sel_msg     = cpu_req ? ln_msg[cpu_idx] : BUS_NONE;
    assign sel_cpu_res = cpu_req ? ln_cpu_res[cpu_idx] : LN_INV;
    assign sel_hit     = cpu_req && ln_hit[cpu_idx];
    assign sel_evict   = cpu_req && ln_evict[cpu_idx];
    assign sel_flush   = ln_flush[snp_idx];
    assign sel_snp_res = ln_snp_res[snp_idx];

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_op     <= 2'd0;
            bus_addr   <= '0;
            cpu_hit    <= 1'b0;
            cpu_state  <= 2'd0;
            snp_state  <= 2'd0;
            flush      <= 1'b0;
            flush_addr <= '0;
            evict      <= 1'b0;
            evict_addr <= '0;
        end else begin
            bus_op     <= sel_msg;
            bus_addr   <= (sel_msg != BUS_NONE) ? cpu_addr : '0;
            cpu_hit    <= sel_hit;
            cpu_state  <= sel_cpu_res;
            snp_state  <= sel_snp_res;
            flush      <= sel_flush;
            flush_addr <= sel_flush ? snp_addr : '0;
            evict      <= sel_evict;
            evict_addr <= sel_evict ? {ln_victim[cpu_idx], cpu_idx} : '0;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [1:0]        snp_op,
    input logic [ADDR_W-1:0] snp_addr,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cpu_hit,
    input logic [1:0]        cpu_state,
    input logic [1:0]        snp_state,
    input logic              flush,
    input logic [ADDR_W-1:0] flush_addr,
    input logic              evict,
    input logic [ADDR_W-1:0] evict_addr
);

    logic armed;
    always_ff @(posedge clk) armed <= rst_n;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(cpu_req)) |-> (bus_op == 2'd0 && !cpu_hit && !evict && cpu_state == 2'd0));

    // R2
    read_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cpu_req && !cpu_we)) |-> (cpu_state != 2'd0));

    // R2
    bus_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_op != 2'd0) |-> (bus_addr == $past(cpu_addr)));

    // R3
    write_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cpu_req && cpu_we)) |-> (cpu_state == 2'd2));

    // R4
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (bus_op == 2'd0 && !evict));

    // R6
    flush_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && flush && $past(snp_op) == 2'd1) |-> (snp_state == 2'd1 && flush_addr == $past(snp_addr)));

    // R7
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && flush && $past(snp_op) != 2'd1) |-> (snp_state == 2'd0));

    // R8
    idle_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(snp_op) == 2'd0) |-> (!flush && snp_state == 2'd0));

    // R9
    evict_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && evict) |-> ((bus_op == 2'd1 || bus_op == 2'd2) &&
                              evict_addr[IDX_W-1:0] == bus_addr[IDX_W-1:0]));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0, snp_addr = '0;
    logic [1:0] snp_op = '0;
    logic [1:0] bus_op, cpu_state, snp_state;
    logic [5:0] bus_addr, flush_addr, evict_addr;
    logic       cpu_hit, flush, evict;

    always #2.5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(6), .IDX_W(2)) uut (.*);

    int tests = 0, fails = 0;
    int ms [4];
    int mt [4];

    function automatic logic [26:0] outs();
        return {bus_op, bus_addr, cpu_hit, cpu_state, snp_state, flush, flush_addr, evict, evict_addr};
    endfunction

    task automatic check(input string req, input logic [26:0] got, input logic [26:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // apply one cycle of stimulus; expected values come from the state rules
    task automatic step(input string lbl, input bit rq, input bit we, input logic [5:0] ca,
                        input logic [1:0] so, input logic [5:0] sa);
        logic [1:0] e_bus, e_cs, e_ss;
        logic [5:0] e_ba, e_fa, e_ea;
        logic       e_hit, e_fl, e_ev;
        string      clbl, slbl, use_lbl;
        int ci, ct, si, st;
        ci = int'(ca[1:0]); ct = int'(ca[5:2]);
        si = int'(sa[1:0]); st = int'(sa[5:2]);
        e_bus = 0; e_ba = 0; e_hit = 0; e_cs = 0; e_ss = 0; e_fl = 0; e_fa = 0; e_ev = 0; e_ea = 0;
        clbl = ""; slbl = "";
        if (so != 2'd0) begin
            if (ms[si] != 0 && mt[si] == st) begin
                if (ms[si] == 2) begin
                    e_fl = 1; e_fa = sa;
                    slbl = (so == 2'd1) ? "R6" : "R7";
                end else slbl = "R5";
                ms[si] = (so == 2'd1) ? 1 : 0;
                e_ss = 2'(ms[si]);
            end else slbl = "R8";
        end
        if (rq) begin
            if (ms[ci] != 0 && mt[ci] == ct) begin
                if (we && ms[ci] == 1) begin
                    e_bus = 3; e_ba = ca; ms[ci] = 2; clbl = "R3";
                end else begin
                    e_hit = 1; clbl = "R4";
                end
            end else begin
                if (ms[ci] == 2) begin
                    e_ev = 1; e_ea = {4'(mt[ci]), 2'(ci)}; clbl = "R9";
                end else clbl = we ? "R3" : "R2";
                e_bus = we ? 2'd2 : 2'd1; e_ba = ca;
                ms[ci] = we ? 2 : 1; mt[ci] = ct;
            end
            e_cs = 2'(ms[ci]);
        end
        if (rq && so != 2'd0 && ci == si) clbl = "R10";
        use_lbl = (lbl != "") ? lbl : {clbl, (clbl != "" && slbl != "") ? "/" : "", slbl};
        cpu_req = rq; cpu_we = we; cpu_addr = ca; snp_op = so; snp_addr = sa;
        @(negedge clk);
        check(use_lbl, outs(), {e_bus, e_ba, e_hit, e_cs, e_ss, e_fl, e_fa, e_ev, e_ea});
    endtask

    task automatic do_reset();
        cpu_req = 0; cpu_we = 0; snp_op = 0; cpu_addr = 0; snp_addr = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 4; i++) begin ms[i] = 0; mt[i] = 0; end
        @(negedge clk);
        check("R1", outs(), 27'd0);
    endtask

    initial begin : watchdog
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        do_reset();
        // every line starts Invalid: reads of tag 0 all miss
        for (int i = 0; i < 4; i++) step("R1", 1, 0, 6'(i), 0, 0);

        // directed walk on index 0
        step("R2", 1, 0, 6'h04, 0, 0);     // miss -> S (tag 1 replaces tag 0 S)
        step("R5", 0, 0, 0, 1, 6'h04);     // snoop read miss on S: stays S
        step("R4", 1, 0, 6'h04, 0, 0);     // read hit S
        step("R3", 1, 1, 6'h04, 0, 0);     // upgrade -> M
        step("R4", 1, 1, 6'h04, 0, 0);     // write hit M
        step("R4", 1, 0, 6'h04, 0, 0);     // read hit M
        step("R6", 0, 0, 0, 1, 6'h04);     // snoop read miss on M: flush, S
        step("R4", 1, 0, 6'h04, 0, 0);
        step("R3", 1, 1, 6'h04, 0, 0);
        step("R7", 0, 0, 0, 2, 6'h04);     // snoop write miss on M: flush, I
        step("R3", 1, 1, 6'h04, 0, 0);     // write miss -> M
        step("R7", 0, 0, 0, 3, 6'h04);     // snoop upgrade on M: flush, I
        step("R2", 1, 0, 6'h04, 0, 0);
        step("R5", 0, 0, 0, 3, 6'h04);     // snoop upgrade on S: I
        step("R5", 1, 0, 6'h04, 0, 0);     // read misses again
        step("R8", 0, 0, 0, 1, 6'h08);     // other tag: no effect
        step("R8", 1, 0, 6'h04, 0, 0);     // still S: hit
        step("R3", 1, 1, 6'h04, 0, 0);
        step("R8", 0, 0, 0, 2, 6'h08);
        step("R8", 1, 0, 6'h04, 0, 0);     // still M: hit
        step("R9", 1, 0, 6'h08, 0, 0);     // dirty victim 0x04 leaves
        // same-cycle collisions on index 0
        step("R10", 1, 1, 6'h08, 2, 6'h08); // snoop invalidates S, write misses
        step("R10", 1, 0, 6'h08, 1, 6'h08); // flush to S, read then hits
        step("R10", 1, 1, 6'h08, 1, 6'h08); // S stays, write upgrades
        step("R10", 1, 1, 6'h0C, 2, 6'h08); // flush to I, miss without evict

        // near-exhaustive pseudo-random sweep: 2 tags per index
        lf = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            logic [5:0] ca, sa;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ca = {3'b000, lf[2], lf[4:3]};
            sa = lf[10] ? ca : {3'b000, lf[7], lf[9:8]};
            step("", lf[0], lf[1], ca, lf[6:5], sa);
        end

        // reset in the middle of activity
        do_reset();
        for (int i = 0; i < 8; i++) step("R1", 1, 0, 6'(i), 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule